// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides, at each instruction boundary of an 8-bit processor core, whether an interrupt is entered. If one is, the block runs the entry sequence for it. Pending requests are kept in a small bitmask. A non-maskable request and a one-shot maskable request are set by single-cycle pulses. A parameterised number of level-style maskable sources each have a set strobe and a clear strobe. When the core raises `boundary_i`, it also presents its program counter, status byte and stack pointer. The block then writes the return address and the status to the stack page through a one-access-per-cycle memory port with a ready handshake. It reads the 16-bit vector, low byte first, and returns the new program counter, status and stack pointer together with a one-cycle `done_o` pulse. Each entry adds seven to a running cycle counter.

The block also handles reset. After the power-up reset releases, it fetches the reset vector and sets the status to the interrupt-disable flag alone. At power-up, the program counter, the stack pointer and the cycle counter start at zero. A warm reset request runs the same vector fetch again and clears the halted state. An external halt strobe puts the block in a state where no interrupt is taken. The maskable path is gated by the interrupt-disable flag as it stood at the previous boundary, not by the live flag.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_ni` is low, `busy_o` is 1 and `pc_o`, `sp_o` and `cyc_o` are 0. After release, the block reads 0xFFFC and then 0xFFFD. It then pulses `done_o` with `pc_o` = {byte@0xFFFD, byte@0xFFFC}, `p_o` = 8'h04 and `sp_o` = 0.
- R2: A `rst_req_i` pulse repeats the reset vector fetch of R1 and gives `p_o` = 8'h04. `sp_o` and `cyc_o` are left unchanged.
- R3: Pending requests are acted on only in a cycle where `boundary_i` is 1 and the block is idle. Without a boundary, no memory access starts.
- R4: A pending non-maskable request is taken at a boundary whatever the status flags are. It wins over any pending maskable request. Its vector is read from 0xFFFA (low) and 0xFFFB (high).
- R5: A maskable request (any level source bit or the one-shot bit) is taken only if bit 2 of the status is 0. That bit is taken from `p_i` at the previous idle boundary that took nothing, or from `p_o` after the last entry or reset. Its vector is read from 0xFFFE (low) and 0xFFFF (high).
- R6: Entry writes three bytes in this order: PC[15:8] to 0x0100+S, PC[7:0] to 0x0100+S-1, then the status to 0x0100+S-2. The stack pointer wraps within 8 bits. The status is written with bit 4 cleared and bit 5 set. At the end, `sp_o` = S-3.
- R7: After a maskable entry, `p_o` is `p_i` with bit 4 cleared and bit 2 set. After a non-maskable entry, `p_o` is `p_i` with bit 4 cleared.
- R8: `cyc_o` grows by exactly 7 for each entry and by nothing else.
- R9: At any idle boundary where any request is pending, the non-maskable bit and the one-shot bit are cleared, even when nothing is taken. Level source bits stay set.
- R10: After a `jam_i` pulse, no interrupt of either kind is taken until a reset completes.
- R11: A memory access keeps its address, data and direction stable until `mem_rdy_i` is 1. `busy_o` is high from the cycle after the deciding boundary until the vector is loaded. `done_o` is a one-cycle pulse.
- R12: `src_set_i[k]` sets level bit k and `src_clr_i[k]` clears it. Set wins if both are given together. A cleared source raises no further maskable entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| rst_req_i | input | 1 | Warm reset request pulse |
| boundary_i | input | 1 | Instruction boundary strobe |
| jam_i | input | 1 | Core halted strobe |
| nmi_i | input | 1 | Non-maskable request pulse |
| oneshot_i | input | 1 | One-shot maskable request pulse |
| src_set_i | input | NSRC | Level source set strobes |
| src_clr_i | input | NSRC | Level source clear strobes |
| pc_i | input | 16 | Core program counter at boundary |
| p_i | input | 8 | Core status byte at boundary |
| sp_i | input | 8 | Core stack pointer at boundary |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | New PC, status and stack pointer valid |
| pc_o | output | 16 | New program counter |
| p_o | output | 8 | New status byte |
| sp_o | output | 8 | New stack pointer |
| cyc_o | output | CW | Accumulated entry cycles |
| jammed_o | output | 1 | Halted state |

## Verification
The bench sweeps stack pointers that wrap through 0x00 and 0xFF, and status bytes with bit 4 set and clear, for both kinds of entry. It runs with the memory ready both always high and periodically stalled. A wrong stack wrap, or a status written with bit 4 kept, shows up as a bad push address or a bad push byte. The masking case sets the disable flag on one boundary and clears it on the next. A design that reads the live flag would enter one boundary early. Other runs have the non-maskable and a level request pending together, a one-shot request arriving while masked, and requests arriving while halted. A design without priority would fetch 0xFFFE first. A design that kept the one-shot bit, or the non-maskable bit raised while halted, would later enter when it should not.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;
  localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA;
  localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE;
  localparam logic [DATA_W-1:0] STACK_PG = 8'h01;
  localparam logic [DATA_W-1:0] RST_P = 8'h04;
  localparam int ENTRY_CYC = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST_LO, ST_RST_HI, ST_PSH_HI,
    ST_PSH_LO, ST_PSH_P, ST_VEC_LO, ST_VEC_HI
  } seq_st_e;

  typedef enum logic [1:0] {K_NONE, K_NMI, K_IRQ} ent_kind_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            nmi_i,
  input  logic            oneshot_i,
  input  logic [NSRC-1:0] src_set_i,
  input  logic [NSRC-1:0] src_clr_i,
  input  logic            consume_i,
  output logic            nmi_pend_o,
  output logic            irq_pend_o
);
  logic            nmi_q, one_q;
  logic [NSRC-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q <= 1'b0;
      one_q <= 1'b0;
    end else begin
      if (nmi_i)          nmi_q <= 1'b1;
      else if (consume_i) nmi_q <= 1'b0;
      if (oneshot_i)      one_q <= 1'b1;
      else if (consume_i) one_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           lvl_q[k] <= 1'b0;
      else if (src_set_i[k]) lvl_q[k] <= 1'b1;
      else if (src_clr_i[k]) lvl_q[k] <= 1'b0;
    end
  end

  assign nmi_pend_o = nmi_q;
  assign irq_pend_o = one_q | (|lvl_q);

  // R9
  pulse_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i && !nmi_i && !oneshot_i |=> !nmi_q && !one_q);
  // R12
  lvl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i && (|lvl_q) && !(|src_clr_i) |=> irq_pend_o);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_entry_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      boundary_i,
  input  logic      idle_i,
  input  logic      nmi_pend_i,
  input  logic      irq_pend_i,
  input  logic      i_bit_i,
  input  logic      done_i,
  input  logic      done_i_bit_i,
  input  logic      jam_i,
  input  logic      clr_jam_i,
  output logic      take_o,
  output ent_kind_e kind_o,
  output logic      consume_o,
  output logic      jammed_o
);
  logic i_snap_q, jam_q, at_bnd;

  assign at_bnd = boundary_i && idle_i;

  always_comb begin
    kind_o = K_NONE;
    if (at_bnd && !jam_q) begin
      if (nmi_pend_i)                  kind_o = K_NMI;
      else if (irq_pend_i && !i_snap_q) kind_o = K_IRQ;
    end
  end

  assign take_o    = (kind_o != K_NONE);
  assign consume_o = at_bnd && (nmi_pend_i || irq_pend_i);
  assign jammed_o  = jam_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_snap_q <= 1'b1;
      jam_q    <= 1'b0;
    end else begin
      if (clr_jam_i)  jam_q <= 1'b0;
      else if (jam_i) jam_q <= 1'b1;
      // flag as it stood when the previous instruction started
      if (done_i)                 i_snap_q <= done_i_bit_i;
      else if (at_bnd && !take_o) i_snap_q <= i_bit_i;
    end
  end

  // R5
  irq_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_bnd && !take_o |=> i_snap_q == $past(i_bit_i));
  // R10
  jam_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_q && !clr_jam_i |=> jam_q);
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_entry_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_i,
  input  logic              take_i,
  input  ent_kind_e         kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] p_i,
  input  logic [DATA_W-1:0] sp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rst_done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] p_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [CW-1:0]     cyc_o
);
  localparam logic [DATA_W-1:0] B_MASK = DATA_W'(1) << FLAG_B;
  localparam logic [DATA_W-1:0] U_MASK = DATA_W'(1) << FLAG_U;
  localparam logic [DATA_W-1:0] I_MASK = DATA_W'(1) << FLAG_I;

  seq_st_e           st_q;
  ent_kind_e         kind_q;
  logic [ADDR_W-1:0] pc_q, vec_base;
  logic [DATA_W-1:0] p_q, sp_q, lo_q, p_next;
  logic [CW-1:0]     cyc_q;
  logic              done_q, rst_done_q;

  assign vec_base = (kind_q == K_NMI) ? VEC_NMI : VEC_IRQ;
  assign p_next   = (kind_q == K_IRQ) ? ((p_q & ~B_MASK) | I_MASK) : (p_q & ~B_MASK);

  always_comb begin
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    mem_addr_o  = {STACK_PG, sp_q};
    unique case (st_q)
      ST_RST_LO: mem_addr_o = VEC_RST;
      ST_RST_HI: mem_addr_o = VEC_RST | ADDR_W'(1);
      ST_PSH_HI: begin mem_we_o = 1'b1; mem_wdata_o = pc_q[ADDR_W-1:DATA_W]; end
      ST_PSH_LO: begin mem_we_o = 1'b1; mem_wdata_o = pc_q[DATA_W-1:0]; end
      ST_PSH_P:  begin mem_we_o = 1'b1; mem_wdata_o = (p_q & ~B_MASK) | U_MASK; end
      ST_VEC_LO: mem_addr_o = vec_base;
      ST_VEC_HI: mem_addr_o = vec_base | ADDR_W'(1);
      default:   mem_addr_o = {STACK_PG, sp_q};
    endcase
  end

  assign mem_req_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RST_LO;
      kind_q     <= K_NONE;
      pc_q       <= '0;
      p_q        <= '0;
      sp_q       <= '0;
      lo_q       <= '0;
      cyc_q      <= '0;
      done_q     <= 1'b0;
      rst_done_q <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      rst_done_q <= 1'b0;
      if (rst_req_i) begin
        st_q <= ST_RST_LO;
      end else begin
        unique case (st_q)
          ST_IDLE: if (take_i) begin
            pc_q   <= pc_i;
            p_q    <= p_i;
            sp_q   <= sp_i;
            kind_q <= kind_i;
            cyc_q  <= cyc_q + CW'(ENTRY_CYC);
            st_q   <= ST_PSH_HI;
          end
          ST_RST_LO: if (mem_rdy_i) begin
            lo_q <= mem_rdata_i;
            st_q <= ST_RST_HI;
          end
          ST_RST_HI: if (mem_rdy_i) begin
            pc_q       <= {mem_rdata_i, lo_q};
            p_q        <= RST_P;
            done_q     <= 1'b1;
            rst_done_q <= 1'b1;
            st_q       <= ST_IDLE;
          end
          ST_PSH_HI: if (mem_rdy_i) begin
            sp_q <= sp_q - 1'b1;
            st_q <= ST_PSH_LO;
          end
          ST_PSH_LO: if (mem_rdy_i) begin
            sp_q <= sp_q - 1'b1;
            st_q <= ST_PSH_P;
          end
          ST_PSH_P: if (mem_rdy_i) begin
            sp_q <= sp_q - 1'b1;
            p_q  <= p_next;
            st_q <= ST_VEC_LO;
          end
          ST_VEC_LO: if (mem_rdy_i) begin
            lo_q <= mem_rdata_i;
            st_q <= ST_VEC_HI;
          end
          ST_VEC_HI: if (mem_rdy_i) begin
            pc_q   <= {mem_rdata_i, lo_q};
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign rst_done_o = rst_done_q;
  assign pc_o       = pc_q;
  assign p_o        = p_q;
  assign sp_o       = sp_q;
  assign cyc_o      = cyc_q;

  // R6
  stack_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_addr_o[ADDR_W-1:DATA_W] == STACK_PG);
  // R6
  push_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PSH_P |-> mem_wdata_o[FLAG_U] && !mem_wdata_o[FLAG_B]);
  // R8
  cyc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q != $past(cyc_q) |-> cyc_q == $past(cyc_q) + CW'(ENTRY_CYC));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i && !rst_req_i |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_we_o));
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int CW   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_i,
  input  logic              boundary_i,
  input  logic              jam_i,
  input  logic              nmi_i,
  input  logic              oneshot_i,
  input  logic [NSRC-1:0]   src_set_i,
  input  logic [NSRC-1:0]   src_clr_i,
  input  logic [15:0]       pc_i,
  input  logic [7:0]        p_i,
  input  logic [7:0]        sp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [15:0]       mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       pc_o,
  output logic [7:0]        p_o,
  output logic [7:0]        sp_o,
  output logic [CW-1:0]     cyc_o,
  output logic              jammed_o
);
  logic      nmi_pend, irq_pend, consume, take, rst_done;
  ent_kind_e kind;

  irq_pend #(.NSRC(NSRC)) u_pend (
    .clk_i, .rst_ni, .nmi_i, .oneshot_i, .src_set_i, .src_clr_i,
    .consume_i(consume), .nmi_pend_o(nmi_pend), .irq_pend_o(irq_pend)
  );

  irq_arb u_arb (
    .clk_i, .rst_ni, .boundary_i, .idle_i(!busy_o),
    .nmi_pend_i(nmi_pend), .irq_pend_i(irq_pend),
    .i_bit_i(p_i[FLAG_I]), .done_i(done_o), .done_i_bit_i(p_o[FLAG_I]),
    .jam_i, .clr_jam_i(rst_done),
    .take_o(take), .kind_o(kind), .consume_o(consume), .jammed_o
  );

  irq_seq_fsm #(.CW(CW)) u_fsm (
    .clk_i, .rst_ni, .rst_req_i, .take_i(take), .kind_i(kind),
    .pc_i, .p_i, .sp_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_rdy_i,
    .busy_o, .done_o, .rst_done_o(rst_done), .pc_o, .p_o, .sp_o, .cyc_o
  );

  // R4
  nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && nmi_pend |=> mem_req_o && mem_addr_o[15:8] == STACK_PG);
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int CLK_NS = 10;
  localparam int NSRC = 3;

  logic clk = 0, rst_ni = 0, rst_req = 0, bnd = 0, jam = 0, nmi = 0, one = 0;
  logic [NSRC-1:0] sset = '0, sclr = '0;
  logic [15:0] pc_i = '0, mem_addr, pc_o;
  logic [7:0] p_i = '0, sp_i = '0, mem_wdata, mem_rdata, p_o, sp_o;
  logic mem_req, mem_we, rdy = 1, busy, done, jammed;
  logic [31:0] cyc_o;

  int n_chk = 0, n_bad = 0, ph = 0, wd = 0, log_n = 0;
  bit stall = 0, done_seen = 0;
  logic [15:0] la[8];
  logic [7:0]  ld[8];
  logic        lw[8];
  logic [31:0] exp_cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] vrd(input logic [15:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  assign mem_rdata = vrd(mem_addr);

  irq_entry_seq #(.NSRC(NSRC), .CW(32)) u_dut (
    .clk_i(clk), .rst_ni, .rst_req_i(rst_req), .boundary_i(bnd), .jam_i(jam),
    .nmi_i(nmi), .oneshot_i(one), .src_set_i(sset), .src_clr_i(sclr),
    .pc_i, .p_i, .sp_i, .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_rdy_i(rdy), .busy_o(busy), .done_o(done), .pc_o, .p_o, .sp_o,
    .cyc_o, .jammed_o(jammed)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_bad++;
      $display("FAIL R11 watchdog act=%0d exp=done", wd);
      summary();
      $finish;
    end
  end

  // memory model: ready pattern, access log
  always @(negedge clk) begin
    ph++;
    rdy = stall ? (ph % 3 != 2) : 1'b1;
    #1;
    if (mem_req && rdy && log_n < 8) begin
      la[log_n] = mem_addr; ld[log_n] = mem_wdata; lw[log_n] = mem_we;
      log_n++;
    end
    if (done) done_seen = 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_bnd(input logic [15:0] pc, input logic [7:0] p, input logic [7:0] sp);
    @(negedge clk);
    log_n = 0; done_seen = 0;
    pc_i = pc; p_i = p; sp_i = sp; bnd = 1;
    @(negedge clk);
    bnd = 0;
  endtask

  task automatic wait_done();
    while (!done_seen) @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic exp_entry(input bit is_nmi, input logic [15:0] pc, input logic [7:0] p, input logic [7:0] sp);
    logic [15:0] base;
    logic [7:0] pe;
    string tv;
    base = is_nmi ? 16'hFFFA : 16'hFFFE;
    tv = is_nmi ? "R4 vector" : "R5 vector";
    pe = is_nmi ? (p & 8'hEF) : ((p & 8'hEF) | 8'h04);
    pulse_bnd(pc, p, sp);
    wait_done();
    exp_cyc += 7;
    chk(log_n == 5, "R6 access count", log_n, 5);
    chk(la[0] == {8'h01, sp} && lw[0] && ld[0] == pc[15:8], "R6 push pc_hi", {la[0], ld[0]}, {8'h01, sp, pc[15:8]});
    chk(la[1] == {8'h01, sp - 8'd1} && lw[1] && ld[1] == pc[7:0], "R6 push pc_lo", {la[1], ld[1]}, {8'h01, sp - 8'd1, pc[7:0]});
    chk(la[2] == {8'h01, sp - 8'd2} && lw[2] && ld[2] == ((p & 8'hEF) | 8'h20), "R6 push status",
        {la[2], ld[2]}, {8'h01, sp - 8'd2, (p & 8'hEF) | 8'h20});
    chk(la[3] == base && !lw[3] && la[4] == (base + 16'd1) && !lw[4], tv, {la[3], la[4]}, {base, base + 16'd1});
    chk(pc_o == {vrd(base + 16'd1), vrd(base)}, tv, pc_o, {vrd(base + 16'd1), vrd(base)});
    chk(p_o == pe, "R7 status out", p_o, pe);
    chk(sp_o == sp - 8'd3, "R6 sp out", sp_o, sp - 8'd3);
    chk(cyc_o == exp_cyc, "R8 cycle count", cyc_o, exp_cyc);
  endtask

  task automatic no_entry(input logic [7:0] p, input string tag);
    pulse_bnd(16'h1234, p, 8'hF0);
    repeat (4) @(negedge clk);
    #2;
    chk(log_n == 0 && !busy, tag, log_n, 0);
  endtask

  task automatic exp_reset(input logic [7:0] sp, input string tag);
    wait_done();
    chk(log_n == 2 && la[0] == 16'hFFFC && la[1] == 16'hFFFD && !lw[0] && !lw[1], tag, {la[0], la[1]}, 32'hFFFCFFFD);
    chk(pc_o == {vrd(16'hFFFD), vrd(16'hFFFC)} && p_o == 8'h04, tag, {pc_o, p_o}, {vrd(16'hFFFD), vrd(16'hFFFC), 8'h04});
    chk(sp_o == sp && cyc_o == exp_cyc && !jammed, tag, {sp_o, cyc_o[15:0]}, {sp, exp_cyc[15:0]});
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi = 1; @(negedge clk); nmi = 0;
  endtask
  task automatic pulse_one();
    @(negedge clk); one = 1; @(negedge clk); one = 0;
  endtask
  task automatic src_set(input int k);
    @(negedge clk); sset[k] = 1; @(negedge clk); sset[k] = 0;
  endtask
  task automatic src_clr(input int k);
    @(negedge clk); sclr[k] = 1; @(negedge clk); sclr[k] = 0;
  endtask

  initial begin
    logic [7:0] sps[4];
    logic [7:0] pn[4];
    logic [7:0] pm[4];
    sps = '{8'hFF, 8'h01, 8'h00, 8'h80};
    pn  = '{8'h00, 8'h04, 8'hFF, 8'h30};
    pm  = '{8'h00, 8'h31, 8'hDB, 8'h10};
    repeat (3) @(negedge clk);
    #2;
    chk(busy && cyc_o == 0 && pc_o == 0 && sp_o == 0, "R1 reset state", {busy, cyc_o[7:0], pc_o}, {1'b1, 8'h0, 16'h0});
    @(negedge clk);
    log_n = 0; done_seen = 0; rst_ni = 1;
    exp_reset(8'h00, "R1 power-up vector");

    // non-maskable sweep
    for (int s = 0; s < 4; s++) begin
      for (int q = 0; q < 4; q++) begin
        stall = q[0];
        pulse_nmi();
        exp_entry(1'b1, {sps[s] ^ 8'h5A, pn[q]}, pn[q], sps[s]);
      end
    end

    // maskable sweep via one-shot
    for (int s = 0; s < 4; s++) begin
      for (int q = 0; q < 4; q++) begin
        stall = s[0];
        no_entry(8'h00, "R3 idle boundary");
        pulse_one();
        exp_entry(1'b0, {pm[q], sps[s] ^ 8'hA5}, pm[q], sps[s]);
      end
    end
    stall = 0;

    // R4: priority over a pending level source, then R9 level persists
    no_entry(8'h00, "R3 idle boundary");
    src_set(0);
    pulse_nmi();
    exp_entry(1'b1, 16'h4000, 8'h00, 8'hFD);
    exp_entry(1'b0, 16'h4100, 8'h00, 8'hFA);
    src_clr(0);

    // R5: flag set at previous boundary masks this one
    no_entry(8'h04, "R3 idle boundary");
    src_set(1);
    no_entry(8'h00, "R5 masked by previous flag");
    exp_entry(1'b0, 16'h5000, 8'h00, 8'hE0);
    no_entry(8'h00, "R5 masked after entry");
    exp_entry(1'b0, 16'h5100, 8'h00, 8'hE0);
    src_clr(1);
    no_entry(8'h00, "R12 cleared source");
    no_entry(8'h00, "R12 cleared source");

    // R12: set wins over clear
    @(negedge clk); sset[2] = 1; sclr[2] = 1; @(negedge clk); sset[2] = 0; sclr[2] = 0;
    exp_entry(1'b0, 16'h5200, 8'h00, 8'hC0);
    src_clr(2);
    no_entry(8'h00, "R12 cleared source");

    // R9: one-shot dropped when masked
    no_entry(8'h04, "R3 idle boundary");
    pulse_one();
    no_entry(8'h00, "R9 one-shot masked");
    no_entry(8'h00, "R9 one-shot dropped");

    // R3: no action without boundary
    pulse_nmi();
    repeat (5) @(negedge clk);
    #2;
    chk(!busy && !mem_req, "R3 no boundary", {busy, mem_req}, 0);
    exp_entry(1'b1, 16'h6000, 8'h00, 8'h10);

    // R10: halted blocks both kinds, reset clears
    @(negedge clk); jam = 1; @(negedge clk); jam = 0;
    #2;
    chk(jammed, "R10 halted", jammed, 1);
    pulse_nmi();
    no_entry(8'h00, "R10 nmi blocked");
    src_set(0);
    no_entry(8'h00, "R10 irq blocked");
    src_clr(0);
    @(negedge clk);
    log_n = 0; done_seen = 0; rst_req = 1;
    @(negedge clk); rst_req = 0;
    exp_reset(8'h0D, "R2 warm reset");
    no_entry(8'h00, "R9 nmi dropped while halted");
    pulse_nmi();
    exp_entry(1'b1, 16'h7000, 8'h84, 8'h33);

    summary();
    $finish;
  end
endmodule